// File: doc/BRIEF.md
# Task-File Disk Device Front End

This block is the device side of a parallel disk attachment, seen by the host through eight byte-wide task-file registers. The host loads a sector count, a 24-bit logical block address and a device-select byte, then writes a command code. The block answers three commands. The first is a self-description command, whose 256-word parameter block the host pulls out one word at a time through the data register. The other two are block reads and block writes, which move whole sectors between a small internal sector store and a word-wide DMA handshake port.

A status byte reports progress: busy, ready, data-request and error. A level interrupt line is raised when a command finishes or its data is ready. A read of the status register drops the interrupt. While the device is busy it drops task-file writes, so a host cannot corrupt a transfer in flight. Commands aimed at the second unit on the cable are ignored, because this front end models only unit 0.

Top module: `ata_taskfile_dev`

## Requirements
- R1: After reset the status byte reads 0x40 (ready only), the interrupt line is low and no DMA request is raised.
- R2: Reads at offsets 2 (sector count), 3, 4 and 5 (address bits 7:0, 15:8, 23:16) and 6 (device select) return the last byte written there. Bit 4 of the device byte selects unit 1 and reads back 0 when unit 0 was written. Bit 6 requests logical block addressing.
- R3: A command written at offset 7 while the device is idle makes the status byte read 0x80 (busy only) in the following cycle. Only after that cycle is data-request, completion or error reported.
- R4: Status bit weights are busy 0x80, ready 0x40, fault 0x20, data request 0x08 and error 0x01. During the self-description command (0xEC), status reads 0x48 before each of the 256 data-register reads. It reads 0x40 after the last one.
- R5: Each read of offset 0 during the self-description command returns the next word of the parameter block. Word 0 is 0x0040. Words 10 to 19 hold the 20-character serial text and words 23 to 26 hold the 8-character revision text, first character of each pair in bits 15:8. Word 60 holds the sector capacity. Word 85 is 0x0020 (write cache enabled). All other words are 0.
- R6: The interrupt rises when self-description data becomes ready, when a DMA command completes and when a command ends in error. A status-register read clears it at the next clock edge.
- R7: Write DMA (0xCA) holds the DMA request with busy set. Each acknowledged beat stores the input word at the next address, starting at address × sector words. After count × sector words beats, a one-cycle done pulse occurs, status reads 0x40 and the interrupt rises.
- R8: Read DMA (0xC8) drives the direction output high and presents the stored words in address order on the DMA read bus, one per acknowledged beat, with the same completion behaviour as R7.
- R9: A DMA command is rejected with status 0x41 and the interrupt set, and no DMA request is raised, when the count is 0, when address plus count exceeds the capacity, or when device bit 6 is clear.
- R10: Any other command code ends with status 0x41 and the interrupt set.
- R11: A command written while device bit 4 is set is ignored. Status stays 0x40 and the interrupt stays low.
- R12: A newly accepted command clears a standing error bit.
- R13: Task-file register writes made while busy is set have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Task-file register offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; read side effects take place at the clock edge |
| regWdata | input | 8 | Register write byte |
| regRdata | output | 16 | Register read value, combinational from regAddr |
| intrq | output | 1 | Level interrupt to the host |
| dmaReq | output | 1 | DMA transfer request |
| dmaToHost | output | 1 | High when the DMA direction is device to host |
| dmaAck | input | 1 | DMA beat acknowledge; one word moves per acknowledged cycle |
| dmaWdata | input | 16 | Word from the host during write DMA |
| dmaRdata | output | 16 | Word to the host during read DMA |
| dmaDone | output | 1 | One-cycle pulse after the last DMA beat |

## Verification
The assertions assume that the host never raises a read strobe and a write strobe in the same cycle. They also assume that dmaAck is only driven while dmaReq is high. Under those assumptions, a status read with busy clear is followed by a low interrupt, and the sector count stays unchanged through every busy cycle. The bench drives the register port with separate one-cycle read and write tasks. It raises the acknowledge only after it has seen the request, and drops it as soon as the planned beat count has been reached.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam logic [7:0] CMD_IDENT = 8'hEC;
  localparam logic [7:0] CMD_RDMA  = 8'hC8;
  localparam logic [7:0] CMD_WDMA  = 8'hCA;

  localparam logic [159:0] SERIAL_TXT = "SN0123456789ABCDEFGH";
  localparam logic [63:0]  FWREV_TXT  = "REV1.00 ";

  // ST_DMA_IN: host to device, ST_DMA_OUT: device to host
  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_PIO, ST_DMA_IN, ST_DMA_OUT
  } ctlState_e;

  typedef struct packed {
    logic tfWrEn;
    logic idClr;
    logic idStep;
    logic xferLoad;
    logic xferStep;
    logic ramWr;
  } dpStrobe_t;
endpackage

// File: rtl/ata_tf_datapath.sv
module ata_tf_datapath
  import ata_tf_pkg::*;
#(
  parameter int NUM_SECTORS  = 4,
  parameter int SECTOR_WORDS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic [2:0] regAddr,
  input  logic       regWr,
  input  logic [7:0] regWdata,
  input  logic [7:0] statusByte,
  input  logic       pioActive,
  input  logic [15:0] dmaWdata,
  output logic [15:0] regRdata,
  output logic [15:0] dmaRdata,
  output logic       rangeOk,
  output logic       idLast,
  output logic       xferLast,
  output logic       unitSel,
  output logic [7:0] nsectQ
);
  localparam int RAM_WORDS = NUM_SECTORS * SECTOR_WORDS;
  localparam int ADDR_W    = $clog2(RAM_WORDS);
  localparam int PTR_W     = ADDR_W + 1;

  logic [7:0] lbaLo, lbaMid, lbaHi, devReg;
  logic [7:0] idIdx;
  logic [PTR_W-1:0] xferPtr, endPtr;
  logic [15:0] sectorRam [RAM_WORDS];
  logic [23:0] lba24;
  logic [24:0] lbaEnd;

  assign lba24   = {lbaHi, lbaMid, lbaLo};
  assign lbaEnd  = {1'b0, lba24} + 25'(nsectQ);
  assign rangeOk = devReg[6] && (nsectQ != 8'd0) && (lbaEnd <= 25'(NUM_SECTORS));
  assign idLast  = (idIdx == 8'hFF);
  assign xferLast = (PTR_W'(xferPtr + 1'b1) == endPtr);
  assign unitSel = devReg[4];
  assign dmaRdata = sectorRam[xferPtr[ADDR_W-1:0]];

  function automatic logic [15:0] idWord(input logic [7:0] idx);
    int k;
    k = int'(idx);
    if (k == 0) return 16'h0040;
    if (k >= 10 && k <= 19) return SERIAL_TXT[159 - 16*(k-10) -: 16];
    if (k >= 23 && k <= 26) return FWREV_TXT[63 - 16*(k-23) -: 16];
    if (k == 60) return 16'(NUM_SECTORS);
    if (k == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nsectQ  <= '0;
      lbaLo   <= '0;
      lbaMid  <= '0;
      lbaHi   <= '0;
      devReg  <= '0;
      idIdx   <= '0;
      xferPtr <= '0;
      endPtr  <= '0;
    end else begin
      if (regWr && stb.tfWrEn) begin
        case (regAddr)
          3'd2: nsectQ <= regWdata;
          3'd3: lbaLo  <= regWdata;
          3'd4: lbaMid <= regWdata;
          3'd5: lbaHi  <= regWdata;
          3'd6: devReg <= regWdata;
          default: ;
        endcase
      end
      if (stb.idClr) idIdx <= '0;
      else if (stb.idStep) idIdx <= idIdx + 8'd1;
      if (stb.xferLoad) begin
        xferPtr <= PTR_W'(lba24 * SECTOR_WORDS);
        endPtr  <= PTR_W'(lbaEnd * SECTOR_WORDS);
      end else if (stb.xferStep) begin
        xferPtr <= xferPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.ramWr) sectorRam[xferPtr[ADDR_W-1:0]] <= dmaWdata;
  end

  always_comb begin
    case (regAddr)
      3'd0: regRdata = pioActive ? idWord(idIdx) : 16'h0000;
      3'd2: regRdata = {8'h00, nsectQ};
      3'd3: regRdata = {8'h00, lbaLo};
      3'd4: regRdata = {8'h00, lbaMid};
      3'd5: regRdata = {8'h00, lbaHi};
      3'd6: regRdata = {8'h00, devReg};
      3'd7: regRdata = {8'h00, statusByte};
      default: regRdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  input  logic       dmaAck,
  input  logic       unitSel,
  input  logic       rangeOk,
  input  logic       idLast,
  input  logic       xferLast,
  output dpStrobe_t  stb,
  output logic [7:0] statusByte,
  output logic       pioActive,
  output logic       intrq,
  output logic       dmaReq,
  output logic       dmaToHost,
  output logic       dmaDone
);
  ctlState_e state;
  logic [7:0] cmdReg;
  logic errQ;
  logic bsy, drq, inDma, cmdAccept;

  assign inDma     = (state == ST_DMA_IN) || (state == ST_DMA_OUT);
  assign bsy       = (state == ST_DECODE) || inDma;
  assign drq       = (state == ST_PIO);
  assign pioActive = drq;
  assign dmaReq    = inDma;
  assign dmaToHost = (state == ST_DMA_OUT);
  assign cmdAccept = regWr && (regAddr == 3'd7) && (state == ST_IDLE) && !unitSel;
  assign statusByte = {bsy, ~bsy, 1'b0, 1'b0, drq, 2'b00, errQ};

  always_comb begin
    stb.tfWrEn   = !bsy;
    stb.idClr    = (state == ST_DECODE);
    stb.idStep   = drq && regRd && (regAddr == 3'd0);
    stb.xferLoad = (state == ST_DECODE);
    stb.xferStep = inDma && dmaAck;
    stb.ramWr    = (state == ST_DMA_IN) && dmaAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cmdReg  <= '0;
      errQ    <= 1'b0;
      intrq   <= 1'b0;
      dmaDone <= 1'b0;
    end else begin
      dmaDone <= 1'b0;
      if (regRd && regAddr == 3'd7) intrq <= 1'b0;
      case (state)
        ST_IDLE: if (cmdAccept) begin
          cmdReg <= regWdata;
          errQ   <= 1'b0;
          state  <= ST_DECODE;
        end
        ST_DECODE: begin
          case (cmdReg)
            CMD_IDENT: begin
              state <= ST_PIO;
              intrq <= 1'b1;
            end
            CMD_RDMA, CMD_WDMA: begin
              if (rangeOk) begin
                state <= (cmdReg == CMD_RDMA) ? ST_DMA_OUT : ST_DMA_IN;
              end else begin
                errQ  <= 1'b1;
                intrq <= 1'b1;
                state <= ST_IDLE;
              end
            end
            default: begin
              errQ  <= 1'b1;
              intrq <= 1'b1;
              state <= ST_IDLE;
            end
          endcase
        end
        ST_PIO: if (regRd && regAddr == 3'd0 && idLast) state <= ST_IDLE;
        ST_DMA_IN, ST_DMA_OUT: if (dmaAck && xferLast) begin
          state   <= ST_IDLE;
          intrq   <= 1'b1;
          dmaDone <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_taskfile_dev.sv
module ata_taskfile_dev
  import ata_tf_pkg::*;
#(
  parameter int NUM_SECTORS  = 4,
  parameter int SECTOR_WORDS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [7:0]  regWdata,
  output logic [15:0] regRdata,
  output logic        intrq,
  output logic        dmaReq,
  output logic        dmaToHost,
  input  logic        dmaAck,
  input  logic [15:0] dmaWdata,
  output logic [15:0] dmaRdata,
  output logic        dmaDone
);
  dpStrobe_t  ctlStb;
  logic [7:0] statusByte;
  logic [7:0] nsectQ;
  logic pioActive, rangeOk, idLast, xferLast, unitSel;

  ata_tf_ctrl u_ctrl (
    .clk, .rstN, .regAddr, .regWr, .regRd, .regWdata, .dmaAck,
    .unitSel, .rangeOk, .idLast, .xferLast,
    .stb(ctlStb), .statusByte, .pioActive, .intrq, .dmaReq, .dmaToHost, .dmaDone
  );

  ata_tf_datapath #(.NUM_SECTORS(NUM_SECTORS), .SECTOR_WORDS(SECTOR_WORDS)) u_dp (
    .clk, .rstN, .stb(ctlStb), .regAddr, .regWr, .regWdata, .statusByte,
    .pioActive, .dmaWdata, .regRdata, .dmaRdata, .rangeOk, .idLast,
    .xferLast, .unitSel, .nsectQ
  );
endmodule

// File: rtl/ata_tf_checker.sv
module ata_tf_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] regAddr,
  input logic       regWr,
  input logic       regRd,
  input logic       intrq,
  input logic       dmaReq,
  input logic       dmaDone,
  input logic [7:0] statusByte,
  input logic       unitSel,
  input logic [7:0] nsectQ
);
  // R7
  dmareq_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> statusByte[7]);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |-> (!dmaReq && !statusByte[7] && statusByte[6]));

  // R4
  drq_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[3] |-> (!statusByte[7] && statusByte[6]));

  // R6
  intr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && !regWr && regAddr == 3'd7 && !statusByte[7]) |=> !intrq);

  // R3
  cmd_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd7 && !statusByte[7] && !statusByte[3] && !unitSel)
      |=> (statusByte[7] && !statusByte[3]));

  // R13
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7] |=> $stable(nsectQ));
endmodule

bind ata_taskfile_dev ata_tf_checker u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
  .intrq(intrq), .dmaReq(dmaReq), .dmaDone(dmaDone), .statusByte(statusByte),
  .unitSel(unitSel), .nsectQ(nsectQ)
);

// File: tb/tb_ata_taskfile_dev.sv
module tb_ata_taskfile_dev;
  localparam int NSEC = 4;
  localparam int SW   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [15:0] regRdata;
  logic intrq, dmaReq, dmaToHost, dmaDone;
  logic dmaAck = 1'b0;
  logic [15:0] dmaWdata = '0;
  logic [15:0] dmaRdata;

  int nChecks = 0;
  int nFails = 0;
  logic [15:0] model [NSEC*SW];
  logic [15:0] rv;
  logic [159:0] snTxt = "SN0123456789ABCDEFGH";
  logic [63:0]  fwTxt = "REV1.00 ";

  always #4 clk = ~clk;

  ata_taskfile_dev #(.NUM_SECTORS(NSEC), .SECTOR_WORDS(SW)) dut (
    .clk, .rstN, .regAddr, .regWr, .regRd, .regWdata, .regRdata, .intrq,
    .dmaReq, .dmaToHost, .dmaAck, .dmaWdata, .dmaRdata, .dmaDone
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    regAddr = a; regRd = 1'b1;
    #1 v = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  function automatic logic [15:0] expId(input int w);
    int i;
    if (w == 0) return 16'h0040;
    if (w >= 10 && w <= 19) begin
      i = 2 * (w - 10);
      return {snTxt[8*(19-i) +: 8], snTxt[8*(18-i) +: 8]};
    end
    if (w >= 23 && w <= 26) begin
      i = 2 * (w - 23);
      return {fwTxt[8*(7-i) +: 8], fwTxt[8*(6-i) +: 8]};
    end
    if (w == 60) return 16'(NSEC);
    if (w == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  task automatic setup(input int lba, input int ns, input logic [7:0] dev);
    wr(3'd2, 8'(ns));
    wr(3'd3, 8'(lba));
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h00);
    wr(3'd6, dev);
  endtask

  task automatic writeDma(input int lba, input int ns, input int seed, input bit poke);
    logic [15:0] v;
    setup(lba, ns, 8'h40);
    wr(3'd7, 8'hCA);
    rd(3'd7, v); check("R3 busy after WRITE DMA", v, 16'h0080);
    check("R7 request raised", dmaReq, 1'b1);
    check("R7 direction host to device", dmaToHost, 1'b0);
    if (poke) wr(3'd2, 8'h77);
    for (int i = 0; i < ns*SW; i++) begin
      dmaAck = 1'b1;
      dmaWdata = 16'(seed + i*37);
      model[lba*SW + i] = 16'(seed + i*37);
      @(negedge clk);
    end
    dmaAck = 1'b0;
    check("R7 done pulse", dmaDone, 1'b1);
    check("R7 request dropped", dmaReq, 1'b0);
    check("R7 interrupt on completion", intrq, 1'b1);
    @(negedge clk);
    check("R7 done is one cycle", dmaDone, 1'b0);
    rd(3'd7, v); check("R7 status after WRITE DMA", v, 16'h0040);
    check("R6 status read clears interrupt", intrq, 1'b0);
    if (poke) begin
      rd(3'd2, v); check("R13 count write while busy ignored", v, 16'(ns));
    end
  endtask

  task automatic finish();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd7, v); check("R1 reset status", v, 16'h0040);
    check("R1 reset interrupt", intrq, 1'b0);
    check("R1 reset DMA request", dmaReq, 1'b0);

    // R2 register readback over all byte-wide registers
    for (int a = 2; a <= 6; a++) begin
      wr(3'(a), 8'(8'h1B * a) & ((a == 6) ? 8'hEF : 8'hFF));
      rd(3'(a), v);
      check("R2 register readback", v, 16'(8'(8'h1B * a) & ((a == 6) ? 8'hEF : 8'hFF)));
    end
    wr(3'd6, 8'h40);
    rd(3'd6, v); check("R2 unit 0 bit4 reads 0", v[4], 1'b0);

    // R3 R4 R5 R6 self-description command
    wr(3'd7, 8'hEC);
    rd(3'd7, v); check("R3 busy after IDENTIFY", v, 16'h0080);
    check("R6 interrupt on data ready", intrq, 1'b1);
    for (int w = 0; w < 256; w++) begin
      rd(3'd7, v); check("R4 status before data word", v, 16'h0048);
      rd(3'd0, v); check("R5 parameter word", v, expId(w));
    end
    rd(3'd7, v); check("R4 status after last word", v, 16'h0040);
    check("R6 interrupt cleared", intrq, 1'b0);

    // R7 R13 write DMA: fill all sectors, then overwrite two
    writeDma(0, NSEC, 16'h1000, 1'b0);
    writeDma(1, 2, 16'hB000, 1'b1);

    // R8 R9 sweep of address and count with read DMA
    for (int lba = 0; lba <= NSEC; lba++) begin
      for (int ns = 0; ns <= NSEC; ns++) begin
        setup(lba, ns, 8'h40);
        wr(3'd7, 8'hC8);
        rd(3'd7, v); check("R3 busy after READ DMA", v, 16'h0080);
        if (ns != 0 && lba + ns <= NSEC) begin
          check("R8 request raised", dmaReq, 1'b1);
          check("R8 direction device to host", dmaToHost, 1'b1);
          for (int i = 0; i < ns*SW; i++) begin
            dmaAck = 1'b1;
            #1 check("R8 read word", dmaRdata, model[lba*SW + i]);
            @(negedge clk);
          end
          dmaAck = 1'b0;
          check("R8 done pulse", dmaDone, 1'b1);
          check("R8 interrupt", intrq, 1'b1);
          rd(3'd7, v); check("R8 status after READ DMA", v, 16'h0040);
        end else begin
          check("R9 no request on reject", dmaReq, 1'b0);
          check("R9 interrupt on reject", intrq, 1'b1);
          rd(3'd7, v); check("R9 reject status", v, 16'h0041);
        end
      end
    end

    // R9 LBA bit clear
    setup(0, 1, 8'h00);
    wr(3'd7, 8'hC8);
    rd(3'd7, v);
    check("R9 no request without LBA bit", dmaReq, 1'b0);
    rd(3'd7, v); check("R9 status without LBA bit", v, 16'h0041);

    // R10 unknown command
    wr(3'd6, 8'h40);
    wr(3'd7, 8'h55);
    rd(3'd7, v);
    check("R10 interrupt on unknown", intrq, 1'b1);
    rd(3'd7, v); check("R10 status on unknown", v, 16'h0041);

    // R12 accepted command clears error
    setup(2, 1, 8'h40);
    wr(3'd7, 8'hC8);
    rd(3'd7, v); check("R12 error cleared on accept", v, 16'h0080);
    for (int i = 0; i < SW; i++) begin
      dmaAck = 1'b1;
      @(negedge clk);
    end
    dmaAck = 1'b0;
    rd(3'd7, v); check("R12 status after clean command", v, 16'h0040);

    // R11 command to unit 1 ignored
    wr(3'd6, 8'h50);
    wr(3'd7, 8'hEC);
    rd(3'd7, v); check("R11 unit 1 command ignored", v, 16'h0040);
    @(negedge clk);
    check("R11 no interrupt", intrq, 1'b0);
    rd(3'd6, v); check("R11 device byte kept", v, 16'h0050);

    finish();
  end
endmodule